// File: doc/BRIEF.md
# DMA Channel Request Control Bank

This block holds the per-channel state bits that a multi-channel DMA controller keeps outside its transfer engines: a request-enable bit, an interrupt flag, an error flag and a done flag for every channel, along with a sampled copy of the peripheral request lines. Software changes one channel's bit by writing that channel's number to a dedicated command register. Each command register performs one fixed action, set or clear, on one bitmap. No mask is written, so a driver never has to read, modify and write back a shared word while other channels are changing.

The transfer engines report completion and faults through per-channel event pulses. The bank turns these into sticky flags that software later clears by index. Full bitmaps can be read back as 32-bit words. Channels 0 to 31 appear in a low word and channels 32 and up appear in a high word. The request-enable bitmap drives the engines directly. A single interrupt line is raised while any channel's interrupt flag is set.

Top module: `chreq_bank`

## Requirements
- R1: A write of value N (the whole 32-bit data word) to the enable-set command (address 0x0), with N below the channel count, sets bit N of `req_en_o` one cycle later and leaves every other bit unchanged.
- R2: A write of value N to the enable-clear command (address 0x1) clears bit N of `req_en_o` one cycle later and leaves every other bit unchanged.
- R3: A pulse on `eng_done[N]` sets interrupt flag N. A write of N to the interrupt-clear command (address 0x2) clears only interrupt flag N. The interrupt bitmap reads at 0xA (channels 0–31) and 0xB (channels 32 and up).
- R4: A pulse on `eng_err[N]` sets error flag N. A write of N to the error-clear command (address 0x3) clears only error flag N. The error bitmap reads at 0xC (low) and 0xD (high).
- R5: A pulse on `eng_done[N]` sets done flag N. A write of N to the done-clear command (address 0x4) clears only done flag N. The done bitmap reads at 0xE (low) and 0xF (high). The enable bitmap reads at 0x8 (low) and 0x9 (high).
- R6: The request-status words at 0x6 (channels 0–31) and 0x7 (channels 32 and up) show `hw_req` as sampled at the previous clock edge. Bit k of a high word is channel 32+k.
- R7: When an engine event for a flag arrives in the same cycle as a software clear of that flag, the flag reads 0 in the following cycle and 1 in the cycle after that.
- R8: A command write whose value is at or above the channel count changes no bitmap.
- R9: `irq_o` is high in a cycle exactly when at least one interrupt flag was set in the previous cycle.
- R10: `rdata` is registered. It returns, one cycle later, the word selected by `addr`, using the state before that cycle's update. Unmapped addresses and command addresses read 0. After reset every bitmap, `rdata` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address for writes and reads |
| wdata | input | 32 | Write data; for commands, the channel number |
| rdata | output | 32 | Registered read data |
| hw_req | input | NUM_CH | Peripheral request lines |
| eng_done | input | NUM_CH | Per-channel completion pulses from the engines |
| eng_err | input | NUM_CH | Per-channel fault pulses from the engines |
| req_en_o | output | NUM_CH | Request-enable bitmap to the engines |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Directed cases come first:
- Commands are aimed at channel 3 and at channel 39, which shows that indices below and above 32 land in the right word.
- Out-of-range values 40 and all-ones are written, which separates a correct range check from simple truncation of the index.
- An engine event is made to collide with a clear, so the one-cycle-late re-set can be told apart from a dropped event and from an event that beats the clear.

A long random mix of commands, reads, engine pulses and request patterns then exercises every flag bank against a bench model. This model is what exposes any cross-talk between channels or between bitmaps.

// File: rtl/chreq_pkg.sv
package chreq_pkg;
  localparam int ADDR_W = 4;
  localparam int WORD_W = 32;
  localparam int MAP_W  = 64;

  // command registers: written value is a channel number
  localparam logic [ADDR_W-1:0] A_ENA_SET = 4'h0;
  localparam logic [ADDR_W-1:0] A_ENA_CLR = 4'h1;
  localparam logic [ADDR_W-1:0] A_IRQ_CLR = 4'h2;
  localparam logic [ADDR_W-1:0] A_ERR_CLR = 4'h3;
  localparam logic [ADDR_W-1:0] A_DNE_CLR = 4'h4;
  localparam int NUM_CMD = 5;

  // bitmap read words
  localparam logic [ADDR_W-1:0] A_HRQ_LO = 4'h6;
  localparam logic [ADDR_W-1:0] A_HRQ_HI = 4'h7;
  localparam logic [ADDR_W-1:0] A_ENA_LO = 4'h8;
  localparam logic [ADDR_W-1:0] A_ENA_HI = 4'h9;
  localparam logic [ADDR_W-1:0] A_IRQ_LO = 4'hA;
  localparam logic [ADDR_W-1:0] A_IRQ_HI = 4'hB;
  localparam logic [ADDR_W-1:0] A_ERR_LO = 4'hC;
  localparam logic [ADDR_W-1:0] A_ERR_HI = 4'hD;
  localparam logic [ADDR_W-1:0] A_DNE_LO = 4'hE;
  localparam logic [ADDR_W-1:0] A_DNE_HI = 4'hF;
endpackage

// File: rtl/chreq_idx_dec.sv
module chreq_idx_dec
  import chreq_pkg::*;
#(
  parameter int NUM_CH = 40,
  parameter int TARGET = 0
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [NUM_CH-1:0] mask
);
  logic hit;
  assign hit = wr_en && (addr == ADDR_W'(TARGET));

  // one comparator per channel; a value >= NUM_CH matches none
  for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
    assign mask[i] = hit && (wdata == WORD_W'(i));
  end
endmodule

// File: rtl/chreq_flag_bank.sv
module chreq_flag_bank #(
  parameter int NUM_CH = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] sw_set,
  input  logic [NUM_CH-1:0] sw_clr,
  input  logic [NUM_CH-1:0] hw_set,
  output logic [NUM_CH-1:0] flags_q
);
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] flags_d;

  // a clear beats any set in its own cycle; an engine event that lost
  // to a clear is held one cycle and applied unconditionally next
  always_comb begin
    flags_d = ((flags_q | sw_set | hw_set) & ~sw_clr) | pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      pend_q  <= '0;
    end else begin
      flags_q <= flags_d;
      pend_q  <= hw_set & sw_clr;
    end
  end

  // R3 R4 R5
  hw_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((hw_set & ~sw_clr) != '0) |=> ((flags_q & $past(hw_set & ~sw_clr)) == $past(hw_set & ~sw_clr)));

  // R7
  clr_first_chk: assert property (@(posedge clk) disable iff (rst)
    ((hw_set & sw_clr & ~pend_q) != '0) |=> ((flags_q & $past(hw_set & sw_clr & ~pend_q)) == '0));

  // R7
  late_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((hw_set & sw_clr) != '0) |-> ##2 ((flags_q & $past(hw_set & sw_clr, 2)) == $past(hw_set & sw_clr, 2)));
endmodule

// File: rtl/chreq_rd_mux.sv
module chreq_rd_mux
  import chreq_pkg::*;
#(
  parameter int NUM_CH = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_CH-1:0] ena,
  input  logic [NUM_CH-1:0] irq,
  input  logic [NUM_CH-1:0] err,
  input  logic [NUM_CH-1:0] dne,
  input  logic [NUM_CH-1:0] hrq,
  output logic [WORD_W-1:0] rdata
);
  logic [MAP_W-1:0] p_ena, p_irq, p_err, p_dne, p_hrq;
  logic [WORD_W-1:0] sel;

  always_comb begin
    p_ena = '0; p_ena[NUM_CH-1:0] = ena;
    p_irq = '0; p_irq[NUM_CH-1:0] = irq;
    p_err = '0; p_err[NUM_CH-1:0] = err;
    p_dne = '0; p_dne[NUM_CH-1:0] = dne;
    p_hrq = '0; p_hrq[NUM_CH-1:0] = hrq;
    case (addr)
      A_HRQ_LO: sel = p_hrq[WORD_W-1:0];
      A_HRQ_HI: sel = p_hrq[MAP_W-1:WORD_W];
      A_ENA_LO: sel = p_ena[WORD_W-1:0];
      A_ENA_HI: sel = p_ena[MAP_W-1:WORD_W];
      A_IRQ_LO: sel = p_irq[WORD_W-1:0];
      A_IRQ_HI: sel = p_irq[MAP_W-1:WORD_W];
      A_ERR_LO: sel = p_err[WORD_W-1:0];
      A_ERR_HI: sel = p_err[MAP_W-1:WORD_W];
      A_DNE_LO: sel = p_dne[WORD_W-1:0];
      A_DNE_HI: sel = p_dne[MAP_W-1:WORD_W];
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/chreq_bank.sv
module chreq_bank
  import chreq_pkg::*;
#(
  parameter int NUM_CH = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic [NUM_CH-1:0] eng_done,
  input  logic [NUM_CH-1:0] eng_err,
  output logic [NUM_CH-1:0] req_en_o,
  output logic              irq_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CMD-1:0][NUM_CH-1:0] cmd;
  logic [NUM_CH-1:0] irq_q, err_q, dne_q, hrq_q;
  logic [NUM_CH-1:0] none;
  assign none = '0;

  for (genvar k = 0; k < NUM_CMD; k++) begin : g_dec
    chreq_idx_dec #(.NUM_CH(NUM_CH), .TARGET(k)) u_dec (
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .mask(cmd[k])
    );
  end

  chreq_flag_bank #(.NUM_CH(NUM_CH)) u_ena (
    .clk(clk), .rst(rst), .sw_set(cmd[int'(A_ENA_SET)]), .sw_clr(cmd[int'(A_ENA_CLR)]),
    .hw_set(none), .flags_q(req_en_o)
  );
  chreq_flag_bank #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst(rst), .sw_set(none), .sw_clr(cmd[int'(A_IRQ_CLR)]),
    .hw_set(eng_done), .flags_q(irq_q)
  );
  chreq_flag_bank #(.NUM_CH(NUM_CH)) u_err (
    .clk(clk), .rst(rst), .sw_set(none), .sw_clr(cmd[int'(A_ERR_CLR)]),
    .hw_set(eng_err), .flags_q(err_q)
  );
  chreq_flag_bank #(.NUM_CH(NUM_CH)) u_dne (
    .clk(clk), .rst(rst), .sw_set(none), .sw_clr(cmd[int'(A_DNE_CLR)]),
    .hw_set(eng_done), .flags_q(dne_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hrq_q <= '0;
      irq_o <= 1'b0;
    end else begin
      hrq_q <= hw_req;
      irq_o <= |irq_q;
    end
  end

  chreq_rd_mux #(.NUM_CH(NUM_CH)) u_rd (
    .clk(clk), .rst(rst), .addr(addr), .ena(req_en_o), .irq(irq_q),
    .err(err_q), .dne(dne_q), .hrq(hrq_q), .rdata(rdata)
  );

  // R1
  ena_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_ENA_SET && wdata < NUM_CH) |=> req_en_o[$past(wdata[CH_W-1:0])]);

  // R2
  ena_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_ENA_CLR && wdata < NUM_CH) |=> !req_en_o[$past(wdata[CH_W-1:0])]);

  // R8
  bad_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata >= NUM_CH) |=> $stable(req_en_o));

  // R6
  hrq_sample_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (hrq_q == $past(hw_req)));

  // R9
  irq_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q != '0) |=> irq_o);

  // R9
  irq_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q == '0) |=> !irq_o);
endmodule

// File: tb/chreq_bank_test.sv
`timescale 1ns/1ps
module chreq_bank_test;
  localparam int NUM_CH = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NUM_CH-1:0] hw_req = '0, eng_done = '0, eng_err = '0;
  logic [NUM_CH-1:0] req_en_o;
  logic irq_o;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  logic [63:0] m_ena, m_irq, m_err, m_dne, m_hrq, p_irq, p_err, p_dne;
  logic m_irq_o;
  logic [31:0] m_rd;

  always #2 clk = ~clk;

  chreq_bank #(.NUM_CH(NUM_CH)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .hw_req(hw_req), .eng_done(eng_done), .eng_err(eng_err),
    .req_en_o(req_en_o), .irq_o(irq_o)
  );

  function automatic logic [63:0] pad(input logic [NUM_CH-1:0] x);
    logic [63:0] p;
    p = '0;
    p[NUM_CH-1:0] = x;
    return p;
  endfunction

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    case (a)
      4'h6: return m_hrq[31:0];
      4'h7: return m_hrq[63:32];
      4'h8: return m_ena[31:0];
      4'h9: return m_ena[63:32];
      4'hA: return m_irq[31:0];
      4'hB: return m_irq[63:32];
      4'hC: return m_err[31:0];
      4'hD: return m_err[63:32];
      4'hE: return m_dne[31:0];
      4'hF: return m_dne[63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [3:0] a);
    case (a)
      4'h6, 4'h7: return "R6";
      4'h8, 4'h9: return "R1";
      4'hA, 4'hB: return "R3";
      4'hC, 4'hD: return "R4";
      4'hE, 4'hF: return "R5";
      default:    return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ena = '0; m_irq = '0; m_err = '0; m_dne = '0; m_hrq = '0;
    p_irq = '0; p_err = '0; p_dne = '0; m_irq_o = 1'b0; m_rd = '0;
  endtask

  task automatic model_step();
    logic [63:0] se, ce, ci, cr, cd, hd, he;
    se = '0; ce = '0; ci = '0; cr = '0; cd = '0;
    if (wr_en && wdata < NUM_CH) begin
      case (addr)
        4'h0: se[wdata[5:0]] = 1'b1;
        4'h1: ce[wdata[5:0]] = 1'b1;
        4'h2: ci[wdata[5:0]] = 1'b1;
        4'h3: cr[wdata[5:0]] = 1'b1;
        4'h4: cd[wdata[5:0]] = 1'b1;
        default: ;
      endcase
    end
    hd = pad(eng_done);
    he = pad(eng_err);
    m_rd    = model_rd(addr);
    m_irq_o = |m_irq;
    m_ena   = (m_ena | se) & ~ce;
    m_irq   = ((m_irq | hd) & ~ci) | p_irq;  p_irq = hd & ci;
    m_err   = ((m_err | he) & ~cr) | p_err;  p_err = he & cr;
    m_dne   = ((m_dne | hd) & ~cd) | p_dne;  p_dne = hd & cd;
    m_hrq   = pad(hw_req);
  endtask

  // one clock; inputs were set at the previous falling edge
  task automatic tick(input string tag);
    string rt;
    rt = (tag == "") ? rd_tag(addr) : tag;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(rt, {32'h0, rdata}, {32'h0, m_rd});
    chk((tag == "") ? "R1" : tag, pad(req_en_o), m_ena);
    chk((tag == "") ? "R9" : tag, {63'h0, irq_o}, {63'h0, m_irq_o});
  endtask

  task automatic cmd(input logic [3:0] a, input logic [31:0] v, input string tag);
    wr_en = 1'b1; addr = a; wdata = v;
    tick(tag);
    wr_en = 1'b0; addr = 4'h5; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    addr = a;
    tick(tag);
    tick(tag);
    addr = 4'h5;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] keep;
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10", {32'h0, rdata}, 64'h0);
    chk("R10", pad(req_en_o), 64'h0);
    chk("R10", {63'h0, irq_o}, 64'h0);
    for (int a = 6; a < 16; a++) rd(4'(a), "R10");

    // R1 / R2 low and high word indices
    cmd(4'h0, 32'd3, "R1");
    chk("R1", pad(req_en_o), 64'h8);
    cmd(4'h0, 32'd39, "R1");
    chk("R1", pad(req_en_o), 64'h80_0000_0008);
    rd(4'h9, "R1");
    chk("R1", {32'h0, rdata}, 64'h80);
    cmd(4'h1, 32'd3, "R2");
    chk("R2", pad(req_en_o), 64'h80_0000_0000);

    // R8 out-of-range values
    keep = pad(req_en_o);
    cmd(4'h0, 32'd40, "R8");
    cmd(4'h1, 32'd39 + 32'd256, "R8");
    cmd(4'h0, 32'hFFFF_FFFF, "R8");
    chk("R8", pad(req_en_o), keep);

    // R3 R5 R9 completion event on channel 5
    eng_done[5] = 1'b1;
    tick("R3");
    eng_done = '0;
    tick("R9");
    chk("R9", {63'h0, irq_o}, 64'h1);
    rd(4'hA, "R3");
    chk("R3", {32'h0, rdata}, 64'h20);
    rd(4'hE, "R5");
    chk("R5", {32'h0, rdata}, 64'h20);
    cmd(4'h2, 32'd5, "R3");
    cmd(4'h4, 32'd5, "R5");
    rd(4'hE, "R5");
    chk("R5", {32'h0, rdata}, 64'h0);

    // R4 fault on channel 35
    eng_err[35] = 1'b1;
    tick("R4");
    eng_err = '0;
    rd(4'hD, "R4");
    chk("R4", {32'h0, rdata}, 64'h8);
    cmd(4'h3, 32'd35, "R4");

    // R6 request status split
    hw_req = '0; hw_req[1] = 1'b1; hw_req[33] = 1'b1;
    tick("R6");
    rd(4'h6, "R6");
    chk("R6", {32'h0, rdata}, 64'h2);
    rd(4'h7, "R6");
    chk("R6", {32'h0, rdata}, 64'h2);
    hw_req = '0;

    // R7 event collides with clear on channel 7
    eng_err[7] = 1'b1;
    tick("R7");
    eng_err[7] = 1'b1; wr_en = 1'b1; addr = 4'h3; wdata = 32'd7;
    tick("R7");
    eng_err = '0; wr_en = 1'b0; addr = 4'hC;
    tick("R7");
    chk("R7", {63'h0, rdata[7]}, 64'h0);
    tick("R7");
    chk("R7", {63'h0, rdata[7]}, 64'h1);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      wr_en = ($urandom % 3) == 0;
      addr  = 4'($urandom);
      wdata = (($urandom % 10) == 0) ? $urandom : ($urandom % 48);
      eng_done = (($urandom % 6) == 0) ? NUM_CH'(64'd1 << ($urandom % NUM_CH)) : '0;
      eng_err  = (($urandom % 8) == 0) ? NUM_CH'(64'd1 << ($urandom % NUM_CH)) : '0;
      if (($urandom % 4) == 0) hw_req = NUM_CH'({$urandom, $urandom});
      tick("");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule